// File: doc/BRIEF.md
# Always-On IO Retention Controller

This block lives in a small always-on power island and supervises a low-power state in which the main supplies are switched off. Only a set of wake-capable pads stays alive during this state. Software in the main domain arms the state with a guarded handshake. It first stages a 32-bit key, then raises a load strobe. The strobe is resynchronised into the always-on clock, and its rising edge copies the staged key into a latch that keeps its value. When the copied key equals the configured constant, the retention flag toggles. Loading the constant once arms retention, and loading it a second time disarms it.

While retention is armed, the block freezes the isolation control at the value it had when arming took place. It also holds the power-on and high-voltage reset lines at their inactive high level. An external power-enable output starts high. Software drops it with a control write, so that the regulator removes the main rails. A transition on any pad whose wake enable and the global wake enable are both set raises the power-enable output again on its own. When retention is armed, such a transition also sets a sticky per-pad flag. After power returns, software reads the latched key, the retention status and the flags to validate the episode and find the pad that caused the wake.

Top module: `ioret_ctrl`

## Requirements
- R1: After reset, retention is inactive, the latched key reads 0, power-enable is 1, all wake flags are 0, and `iso_out`, `porz_out` and `hhvz_out` follow their inputs.
- R2: Register map: address 0 writes the staged key and reads the latched key. Address 1 is control: bit 0 is the load strobe, and bit 1 reads back power-enable. Address 2 bit 0 reads retention status. Address 3 reads the wake flags, with bit i for pad i. A load strobe that rises from 0 to 1 copies the staged key into the latch on the third clock edge after the control write. If the copied key equals the magic constant 32'hC0DE5AFE and retention is inactive, retention becomes active on that same edge.
- R3: Loading any key other than the magic constant never changes the retention flag, but the latched key still takes the loaded value.
- R4: Only a 0-to-1 transition of the load strobe captures a key. Writing a new staged key while the strobe falls or stays constant leaves the latched key and the flag unchanged.
- R5: While retention is active, `porz_out` and `hhvz_out` are 1. Otherwise they equal `porz_in` and `hhvz_in`.
- R6: On the arming edge, `iso_in` is captured. While retention is active, `iso_out` holds that captured value whatever `iso_in` does. While retention is inactive, `iso_out` equals `iso_in`.
- R7: A control write with bit 1 equal to 0 clears power-enable on the next edge. A control write with bit 1 equal to 1 never sets it.
- R8: A transition on pad i, with `pad_wake_en[i]` and `glob_wake_en` both 1, sets power-enable on the third clock edge after the change is sampled. A wake on that edge takes priority over a software clear. A transition on a pad without both enables has no effect.
- R9: A wake-qualified transition sets wake flag i only while retention is active. Flags are sticky and are cleared by writing 1 to the matching bit of address 3. A set takes priority over a clear in the same cycle.
- R10: Loading the magic constant while retention is active clears the flag. After that, `iso_out` follows `iso_in` again, the reset lines pass through, and the latched key stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| iso_in | input | 1 | Isolation control from software |
| iso_out | output | 1 | Isolation control to the IO buffers |
| porz_in | input | 1 | Power-on reset, active low |
| hhvz_in | input | 1 | High-voltage reset, active low |
| porz_out | output | 1 | Power-on reset after forcing |
| hhvz_out | output | 1 | High-voltage reset after forcing |
| pad_in | input | 8 | Asynchronous wake-capable pad levels |
| pad_wake_en | input | 8 | Per-pad wake enables |
| glob_wake_en | input | 1 | Global wake enable |
| ret_active | output | 1 | Retention mode active |
| pwr_en_out | output | 1 | External power-enable output |

## Verification
The key handshake is exercised with a non-magic key, with the magic key while inactive, with a staged inverse key while the strobe falls, and with the magic key while active. Between them, these cases separate capture on the edge from capture on the level, and arming from disarming. Pad transitions are applied with the global enable off, on a pad that is not enabled, and on an enabled pad both inside and outside retention. These cases separate the qualification of the power-enable path from the retention gating of the flags. Isolation and reset forcing are probed by moving `iso_in`, `porz_in` and `hhvz_in` while armed and again after disarming.

// File: rtl/ioret_pkg.sv
package ioret_pkg;
    typedef enum logic [1:0] {
        RA_KEY  = 2'd0,
        RA_CTRL = 2'd1,
        RA_STAT = 2'd2,
        RA_WAKE = 2'd3
    } reg_addr_e;

    localparam int unsigned CTRL_LOAD_BIT = 0;
    localparam int unsigned CTRL_PWR_BIT  = 1;
endpackage

// File: rtl/ioret_sync.sv
module ioret_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/ioret_key_latch.sv
module ioret_key_latch #(
    parameter int unsigned     KEY_W = 32,
    parameter logic [KEY_W-1:0] MAGIC = 32'hC0DE5AFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_sync,
    input  logic [KEY_W-1:0] staged_key,
    output logic [KEY_W-1:0] latched_key,
    output logic             ret_flag,
    output logic             load_rise,
    output logic             arm_edge,
    output logic             disarm_edge
);
    typedef struct packed {
        logic             load_prev;
        logic [KEY_W-1:0] key;
        logic             ret;
    } latch_t;

    latch_t st_d, st_q;
    logic   key_match;

    always_comb begin
        st_d        = st_q;
        load_rise   = load_sync & ~st_q.load_prev;
        key_match   = (staged_key == MAGIC);
        arm_edge    = load_rise & key_match & ~st_q.ret;
        disarm_edge = load_rise & key_match &  st_q.ret;

        st_d.load_prev = load_sync;
        if (load_rise) begin
            st_d.key = staged_key;
            if (key_match) st_d.ret = ~st_q.ret;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched_key = st_q.key;
    assign ret_flag    = st_q.ret;
endmodule

// File: rtl/ioret_wake.sv
module ioret_wake #(
    parameter int unsigned NUM_PADS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_sync,
    input  logic [NUM_PADS-1:0] pad_wake_en,
    input  logic                glob_wake_en,
    input  logic                ret_flag,
    input  logic                clr_en,
    input  logic [NUM_PADS-1:0] clr_mask,
    output logic                wake_hit,
    output logic [NUM_PADS-1:0] wake_flags
);
    typedef struct packed {
        logic [NUM_PADS-1:0] prev;
        logic [NUM_PADS-1:0] flags;
    } wake_t;

    wake_t               st_d, st_q;
    logic [NUM_PADS-1:0] pad_hit;

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        assign pad_hit[i] = (pad_sync[i] ^ st_q.prev[i]) & pad_wake_en[i] & glob_wake_en;
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = pad_sync;
        wake_hit   = |pad_hit;
        if (clr_en)   st_d.flags = st_d.flags & ~clr_mask;
        if (ret_flag) st_d.flags = st_d.flags | pad_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_flags = st_q.flags;
endmodule

// File: rtl/ioret_ctrl.sv
module ioret_ctrl #(
    parameter int unsigned      NUM_PADS = 8,
    parameter int unsigned      KEY_W    = 32,
    parameter logic [KEY_W-1:0] MAGIC    = 32'hC0DE5AFE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [KEY_W-1:0]    reg_wdata,
    output logic [KEY_W-1:0]    reg_rdata,
    input  logic                iso_in,
    output logic                iso_out,
    input  logic                porz_in,
    input  logic                hhvz_in,
    output logic                porz_out,
    output logic                hhvz_out,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [NUM_PADS-1:0] pad_wake_en,
    input  logic                glob_wake_en,
    output logic                ret_active,
    output logic                pwr_en_out
);
    import ioret_pkg::*;

    localparam int unsigned PAD_PAD_W = KEY_W - NUM_PADS;

    typedef struct packed {
        logic [KEY_W-1:0] staged;
        logic             load_en;
        logic             pwr_en;
        logic             iso_hold;
    } ctrl_t;

    ctrl_t               st_d, st_q;
    reg_addr_e           addr;
    logic                wr_key, wr_ctrl, wr_wake;
    logic                load_sync;
    logic [NUM_PADS-1:0] pad_sync;
    logic [KEY_W-1:0]    latched_key;
    logic                ret_flag, load_rise, arm_edge, disarm_edge;
    logic                wake_hit;
    logic [NUM_PADS-1:0] wake_flags;
    logic [KEY_W-1:0]    flags_ext;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_key  = reg_wr && (addr == RA_KEY);
    assign wr_ctrl = reg_wr && (addr == RA_CTRL);
    assign wr_wake = reg_wr && (addr == RA_WAKE);

    ioret_sync #(.WIDTH(1)) u_load_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (st_q.load_en),
        .sync_out (load_sync)
    );

    ioret_sync #(.WIDTH(NUM_PADS)) u_pad_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    ioret_key_latch #(.KEY_W(KEY_W), .MAGIC(MAGIC)) u_key (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_sync   (load_sync),
        .staged_key  (st_q.staged),
        .latched_key (latched_key),
        .ret_flag    (ret_flag),
        .load_rise   (load_rise),
        .arm_edge    (arm_edge),
        .disarm_edge (disarm_edge)
    );

    ioret_wake #(.NUM_PADS(NUM_PADS)) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .pad_sync     (pad_sync),
        .pad_wake_en  (pad_wake_en),
        .glob_wake_en (glob_wake_en),
        .ret_flag     (ret_flag),
        .clr_en       (wr_wake),
        .clr_mask     (reg_wdata[NUM_PADS-1:0]),
        .wake_hit     (wake_hit),
        .wake_flags   (wake_flags)
    );

    always_comb begin
        st_d = st_q;
        if (wr_key)  st_d.staged  = reg_wdata;
        if (wr_ctrl) st_d.load_en = reg_wdata[CTRL_LOAD_BIT];
        if (arm_edge)         st_d.iso_hold = iso_in;
        else if (disarm_edge) st_d.iso_hold = 1'b0;
        if (wr_ctrl && !reg_wdata[CTRL_PWR_BIT]) st_d.pwr_en = 1'b0;
        if (wake_hit)                            st_d.pwr_en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pwr_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (PAD_PAD_W > 0) begin : g_ext
            assign flags_ext = {{PAD_PAD_W{1'b0}}, wake_flags};
        end else begin : g_noext
            assign flags_ext = wake_flags;
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_KEY:  reg_rdata = latched_key;
            RA_CTRL: begin
                reg_rdata[CTRL_LOAD_BIT] = st_q.load_en;
                reg_rdata[CTRL_PWR_BIT]  = st_q.pwr_en;
            end
            RA_STAT: reg_rdata[0] = ret_flag;
            RA_WAKE: reg_rdata = flags_ext;
            default: reg_rdata = '0;
        endcase
    end

    assign ret_active = ret_flag;
    assign iso_out    = ret_flag ? st_q.iso_hold : iso_in;
    assign porz_out   = ret_flag | porz_in;
    assign hhvz_out   = ret_flag | hhvz_in;
    assign pwr_en_out = st_q.pwr_en;
endmodule

// File: rtl/ioret_ctrl_chk.sv
module ioret_ctrl_chk #(
    parameter int unsigned NUM_PADS = 8,
    parameter int unsigned KEY_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [1:0]          reg_addr,
    input logic [KEY_W-1:0]    reg_wdata,
    input logic                iso_out,
    input logic                porz_in,
    input logic                hhvz_in,
    input logic                porz_out,
    input logic                hhvz_out,
    input logic                ret_active,
    input logic                pwr_en_out,
    input logic                load_rise,
    input logic                wake_hit,
    input logic [KEY_W-1:0]    latched_key,
    input logic [NUM_PADS-1:0] wake_flags
);
    assert_ret_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_active != $past(ret_active)) |-> $past(load_rise));

    assert_key_only_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latched_key) |-> $past(load_rise));

    assert_resets_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_active |-> (porz_out && hhvz_out));

    assert_resets_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_active |-> (porz_out == porz_in && hhvz_out == hhvz_in));

    assert_iso_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_active && $past(ret_active)) |-> $stable(iso_out));

    assert_pwr_fall_by_sw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_out) |-> $past(reg_wr && reg_addr == 2'd1 && !reg_wdata[1]));

    assert_pwr_rise_by_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_out) |-> $past(wake_hit));

    assert_flag_set_in_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wake_flags & ~$past(wake_flags))) |-> $past(ret_active));
endmodule

bind ioret_ctrl ioret_ctrl_chk #(.NUM_PADS(NUM_PADS), .KEY_W(KEY_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .iso_out     (iso_out),
    .porz_in     (porz_in),
    .hhvz_in     (hhvz_in),
    .porz_out    (porz_out),
    .hhvz_out    (hhvz_out),
    .ret_active  (ret_active),
    .pwr_en_out  (pwr_en_out),
    .load_rise   (load_rise),
    .wake_hit    (wake_hit),
    .latched_key (latched_key),
    .wake_flags  (wake_flags)
);

// File: tb/tb_ioret_ctrl.sv
`timescale 1ns/1ps
module tb_ioret_ctrl;
    localparam logic [31:0] MAGIC  = 32'hC0DE5AFE;
    localparam int          PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        iso_in = 1'b0;
    logic        iso_out;
    logic        porz_in = 1'b0;
    logic        hhvz_in = 1'b0;
    logic        porz_out, hhvz_out;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_wake_en = '0;
    logic        glob_wake_en = 1'b0;
    logic        ret_active, pwr_en_out;

    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    ioret_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iso_in(iso_in),
        .iso_out(iso_out), .porz_in(porz_in), .hhvz_in(hhvz_in),
        .porz_out(porz_out), .hhvz_out(hhvz_out), .pad_in(pad_in),
        .pad_wake_en(pad_wake_en), .glob_wake_en(glob_wake_en),
        .ret_active(ret_active), .pwr_en_out(pwr_en_out)
    );

    // behavioural reference
    logic        m_load, m_ret, m_iso_hold, m_pwr;
    logic [31:0] m_staged, m_key;
    logic [7:0]  m_flags;
    logic        load_hist[$];
    logic [7:0]  pad_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_load = 0; m_ret = 0; m_iso_hold = 0; m_pwr = 1;
            m_staged = 0; m_key = 0; m_flags = 0;
            load_hist = '{0, 0, 0, 0};
            pad_hist  = '{8'h0, 8'h0, 8'h0, 8'h0};
        end else begin
            logic       rise, dropped;
            logic [7:0] hits, dropped8;
            load_hist.push_front(m_load);
            dropped = load_hist.pop_back();
            pad_hist.push_front(pad_in);
            dropped8 = pad_hist.pop_back();
            rise = load_hist[2] && !load_hist[3];
            hits = (pad_hist[2] ^ pad_hist[3]) & pad_wake_en & {8{glob_wake_en}};
            if (reg_wr && reg_addr == 2'd3) m_flags = m_flags & ~reg_wdata[7:0];
            if (m_ret) m_flags = m_flags | hits;
            if (reg_wr && reg_addr == 2'd1 && !reg_wdata[1]) m_pwr = 0;
            if (hits != 0) m_pwr = 1;
            if (rise) begin
                m_key = m_staged;
                if (m_staged == MAGIC) begin
                    if (!m_ret) begin m_ret = 1; m_iso_hold = iso_in; end
                    else        begin m_ret = 0; m_iso_hold = 0; end
                end
            end
            if (reg_wr && reg_addr == 2'd0) m_staged = reg_wdata;
            if (reg_wr && reg_addr == 2'd1) m_load = reg_wdata[0];
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rdata();
        case (reg_addr)
            2'd0:    return m_key;
            2'd1:    return {30'b0, m_pwr, m_load};
            2'd2:    return {31'b0, m_ret};
            default: return {24'b0, m_flags};
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "ret_active", {31'b0, ret_active}, {31'b0, m_ret});
            chk("R2", "reg_rdata", reg_rdata, model_rdata());
            chk("R5", "porz_out", {31'b0, porz_out}, {31'b0, m_ret | porz_in});
            chk("R5", "hhvz_out", {31'b0, hhvz_out}, {31'b0, m_ret | hhvz_in});
            chk("R6", "iso_out", {31'b0, iso_out}, {31'b0, m_ret ? m_iso_hold : iso_in});
            chk("R8", "pwr_en_out", {31'b0, pwr_en_out}, {31'b0, m_pwr});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #2;
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, "read", reg_rdata, exp);
    endtask

    task automatic load_key(input logic [31:0] k, input logic [31:0] after);
        wr(2'd0, k);
        wr(2'd1, 32'h3);
        idle(6);
        wr(2'd0, after);
        wr(2'd1, 32'h2);
        idle(4);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        chk("R1", "ret", {31'b0, ret_active}, 32'h0);
        chk("R1", "pwr", {31'b0, pwr_en_out}, 32'h1);
        chk("R1", "porz pass", {31'b0, porz_out}, 32'h0);
        rd(2'd0, "R1", 32'h0);
        rd(2'd3, "R1", 32'h0);

        // R3 non-magic key
        load_key(32'h12345678, 32'h0);
        rd(2'd0, "R3", 32'h12345678);
        chk("R3", "ret", {31'b0, ret_active}, 32'h0);

        // R2 arm with magic key, staged inverse afterwards (R4)
        iso_in = 1;
        load_key(MAGIC, ~MAGIC);
        chk("R2", "armed", {31'b0, ret_active}, 32'h1);
        rd(2'd2, "R2", 32'h1);
        rd(2'd0, "R4", MAGIC);
        wr(2'd0, 32'hDEADBEEF);
        idle(6);
        rd(2'd0, "R4", MAGIC);

        // R5 / R6 while armed
        porz_in = 0; hhvz_in = 0; iso_in = 0;
        idle(2);
        chk("R5", "porz forced", {31'b0, porz_out}, 32'h1);
        chk("R5", "hhvz forced", {31'b0, hhvz_out}, 32'h1);
        chk("R6", "iso held", {31'b0, iso_out}, 32'h1);

        // R7 power-enable control
        wr(2'd1, 32'h2);
        idle(1);
        chk("R7", "pwr kept", {31'b0, pwr_en_out}, 32'h1);
        wr(2'd1, 32'h0);
        chk("R7", "pwr cleared", {31'b0, pwr_en_out}, 32'h0);
        wr(2'd1, 32'h2);
        idle(1);
        chk("R7", "pwr not set by sw", {31'b0, pwr_en_out}, 32'h0);

        // R8 qualification
        pad_wake_en = 8'h08; glob_wake_en = 0;
        pad_in[3] = 1;
        idle(6);
        chk("R8", "global off", {31'b0, pwr_en_out}, 32'h0);
        glob_wake_en = 1;
        pad_in[5] = 1;
        idle(6);
        chk("R8", "pad not enabled", {31'b0, pwr_en_out}, 32'h0);
        rd(2'd3, "R9", 32'h0);
        pad_in[3] = 0;
        idle(6);
        chk("R8", "wake", {31'b0, pwr_en_out}, 32'h1);

        // R9 sticky flags and W1C
        rd(2'd3, "R9", 32'h08);
        idle(4);
        rd(2'd3, "R9", 32'h08);
        wr(2'd3, 32'h08);
        rd(2'd3, "R9", 32'h0);

        // R10 disarm
        load_key(MAGIC, ~MAGIC);
        chk("R10", "disarmed", {31'b0, ret_active}, 32'h0);
        chk("R10", "iso follows", {31'b0, iso_out}, {31'b0, iso_in});
        chk("R10", "porz pass", {31'b0, porz_out}, 32'h0);
        rd(2'd0, "R10", MAGIC);
        iso_in = 1;
        #1;
        chk("R10", "iso follows high", {31'b0, iso_out}, 32'h1);

        // R8/R9 wake while inactive: power rises, flag stays clear
        wr(2'd1, 32'h0);
        pad_in[3] = 1;
        idle(6);
        chk("R8", "wake inactive", {31'b0, pwr_en_out}, 32'h1);
        rd(2'd3, "R9", 32'h0);

        // R3 non-magic key while armed does not disarm
        load_key(MAGIC, 32'h0);
        load_key(32'h0BADF00D, 32'h0);
        chk("R3", "still armed", {31'b0, ret_active}, 32'h1);
        rd(2'd0, "R3", 32'h0BADF00D);

        idle(4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule